// File: doc/BRIEF.md
# Boundary-Scan Interconnect Test Sequencer

This block is a self-contained test master for a board-level chain of boundary-scan devices. On a start pulse it plays back a fixed program through the four test-port wires. It generates the test clock from the system clock, drives the mode-select and serial data lines, and compares each returned serial bit against an expected value. The program walks the standard 16-state test-port controller. It first forces every device into its reset state and loads the non-intrusive sample/preload instruction, then shifts a stimulus pattern into the update latches of the boundary register. It then switches to the external-test instruction so that the output cells drive the board wires. A second data scan captures what the input cells received and shifts it out for comparison. The program finishes by returning all devices to reset.

Each program step occupies one test-clock period. A step is an entry in an internal 64-deep table that the block computes at elaboration. An entry holds the mode-select bit, the data bit, the expected return bit and a care flag. Return bits whose care flag is clear are not compared. At the end the block raises `done`. It reports `pass` when every compared bit matched, and otherwise reports the index of the first step that mismatched.

Top module: `bscan_seq`

## Requirements
- R1: While reset is active and after reset releases, `tck` is 0, `tms` is 1, `tdi` is 0, and `done`, `pass` and `failStep` are all 0.
- R2: Each program step takes two system clocks: one with `tck` low and one with `tck` high. The default program has 44 steps, so `done` rises exactly 88 clocks after the clock edge that accepts `start`, and `tck` rises 44 times during a run.
- R3: `tms` and `tdi` change only on the clock edge that drives `tck` low (or keeps it low). They never change while `tck` is high. `tdo` is sampled on the edge that drives `tck` high.
- R4: The program opens with five steps at `tms`=1. After them, a device that began in any controller state is in Test-Logic-Reset.
- R5: Instruction shifts expect the captured pattern 001 (shifted out LSB first). The first two returned bits (1, then 0) are compared, which makes the first IR-shift bit step 10 and the second step 11. Sample/preload is code 001 and external test is code 000, each shifted LSB first.
- R6: A returned bit whose care flag is clear never affects the result. In the default program the output-cell bits of the final data scan are not compared.
- R7: `pass` is 1 only while `done` is 1 and every compared bit matched. `done`, `pass` and `failStep` hold until the next accepted `start`.
- R8: On a mismatch, `failStep` holds the index of the first mismatching step, and later mismatches do not change it. When the run passes, `failStep` is 0. In the default program the final data scan returns input cell 0 at step 33 and input cell 1 at step 34.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run neither restarts nor lengthens.
- R10: The last program steps drive `tms`=1, so `tms` is 1 when `done` rises and the devices end in Test-Logic-Reset.
- R11: A `start` accepted after `done` clears the previous result and runs the full program again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, accepted when no run is in progress |
| tdo | input | 1 | Serial data returned by the scan chain |
| tck | output | 1 | Test clock, half the system clock rate during a run |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data into the scan chain |
| done | output | 1 | Program finished; result valid |
| pass | output | 1 | All compared bits matched |
| failStep | output | 6 | Index of the first mismatching step |

## Verification
Several properties are checked on every cycle. Mode-select and data change only while the test clock is low, the test clock is never high for two cycles in a row, and results hold steady once finished. A mid-run start must not stall the clock phase, and the run must end with mode-select high. Other behaviour only shows up in the bench's scenarios, which run the sequencer against a behavioural test-port device wired in loopback. Those scenarios show that the device actually reaches reset after the opening steps, that masked bits are ignored, and that the first-failure index is correct for stuck board wires and stuck serial returns.

// File: rtl/bscan_seq_pkg.sv
package bscan_seq_pkg;

  localparam int IR_LEN = 3;
  localparam logic [IR_LEN-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_LEN-1:0] OP_SAMPLE = 3'b001;

  // One program entry: pin values for one test-clock period plus compare control.
  typedef struct packed {
    logic tms;
    logic tdi;
    logic expTdo;
    logic care;
  } stepT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
    logic sample;
    logic finish;
  } strobeT;

  // Steps: 5 reset + 5 nav + IR + 2 + 2 + DR + 2 + 3 nav + IR + 2 + 2 + DR + 2 + 5 reset
  function automatic int progLen(int irLen, int bndLen);
    return 30 + 2 * irLen + 2 * bndLen;
  endfunction

endpackage

// File: rtl/bscan_prog_rom.sv
module bscan_prog_rom
  import bscan_seq_pkg::*;
#(
  parameter int BND_LEN = 4,
  parameter int DEPTH = 64,
  parameter int AW = 6,
  parameter logic [BND_LEN-1:0] PRELOAD = 4'b0100,
  parameter logic [BND_LEN-1:0] EXPECT = 4'b0010,
  parameter logic [BND_LEN-1:0] CARE = 4'b0011
) (
  input  logic [AW-1:0] addr,
  output stepT          entry
);

  function automatic stepT mk(logic m, logic d, logic e, logic c);
    stepT s;
    s.tms = m;
    s.tdi = d;
    s.expTdo = e;
    s.care = c;
    return s;
  endfunction

  function automatic stepT [DEPTH-1:0] build();
    stepT [DEPTH-1:0] r;
    int p;
    for (int i = 0; i < DEPTH; i++) r[i] = mk(1'b1, 1'b0, 1'b0, 1'b0);
    p = 0;
    // force reset from any state
    for (int i = 0; i < 5; i++) begin r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++; end
    // reset -> idle -> select-DR -> select-IR -> capture-IR -> shift-IR
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    // shift sample/preload code; captured value returns 1,0 first
    for (int i = 0; i < IR_LEN; i++) begin
      r[p] = mk(i == IR_LEN - 1, OP_SAMPLE[i], i == 0, i < 2); p++;
    end
    // update-IR, then select-DR
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    // capture-DR, shift-DR
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    // preload stimulus; returned bits are don't-care
    for (int i = 0; i < BND_LEN; i++) begin
      r[p] = mk(i == BND_LEN - 1, PRELOAD[i], 1'b0, 1'b0); p++;
    end
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    // select-DR -> select-IR -> capture-IR -> shift-IR
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    for (int i = 0; i < IR_LEN; i++) begin
      r[p] = mk(i == IR_LEN - 1, OP_EXTEST[i], i == 0, i < 2); p++;
    end
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b0, 1'b0, 1'b0, 1'b0); p++;
    // read back the captured wire values, shift zeros in
    for (int i = 0; i < BND_LEN; i++) begin
      r[p] = mk(i == BND_LEN - 1, 1'b0, EXPECT[i], CARE[i]); p++;
    end
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++;
    // back to reset
    for (int i = 0; i < 5; i++) begin r[p] = mk(1'b1, 1'b0, 1'b0, 1'b0); p++; end
    return r;
  endfunction

  localparam stepT [DEPTH-1:0] PROG = build();

  assign entry = PROG[addr];

endmodule

// File: rtl/bscan_seq_ctrl.sv
module bscan_seq_ctrl
  import bscan_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastStep,
  output strobeT strobe,
  output logic   busy
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_DONE} stateE;

  stateE state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe = '0;
    nextState = state;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          strobe.clear = 1'b1;
          strobe.load = 1'b1;
          nextState = S_LOW;
        end
      end
      S_LOW: begin
        strobe.sample = 1'b1;
        nextState = S_HIGH;
      end
      S_HIGH: begin
        if (lastStep) begin
          strobe.finish = 1'b1;
          nextState = S_DONE;
        end else begin
          strobe.advance = 1'b1;
          strobe.load = 1'b1;
          nextState = S_LOW;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state == S_LOW) || (state == S_HIGH);

endmodule

// File: rtl/bscan_seq_dp.sv
module bscan_seq_dp
  import bscan_seq_pkg::*;
#(
  parameter int BND_LEN = 4,
  parameter int DEPTH = 64,
  parameter int AW = 6,
  parameter int PROG_LEN = 44,
  parameter logic [BND_LEN-1:0] PRELOAD = 4'b0100,
  parameter logic [BND_LEN-1:0] EXPECT = 4'b0010,
  parameter logic [BND_LEN-1:0] CARE = 4'b0011
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic          tdo,
  output logic          lastStep,
  output logic          tck,
  output logic          tms,
  output logic          tdi,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] failStep
);

  logic [AW-1:0] step;
  logic [AW-1:0] romAddr;
  logic          allMatch;
  logic          mismatch;
  stepT          entry;

  assign romAddr = strobe.clear   ? '0 :
                   strobe.advance ? step + 1'b1 : step;

  bscan_prog_rom #(
    .BND_LEN(BND_LEN), .DEPTH(DEPTH), .AW(AW),
    .PRELOAD(PRELOAD), .EXPECT(EXPECT), .CARE(CARE)
  ) u_rom (
    .addr (romAddr),
    .entry(entry)
  );

  assign lastStep = (step == AW'(PROG_LEN - 1));
  assign mismatch = entry.care && (tdo != entry.expTdo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= '0;
      tck      <= 1'b0;
      tms      <= 1'b1;
      tdi      <= 1'b0;
      done     <= 1'b0;
      allMatch <= 1'b0;
      failStep <= '0;
    end else begin
      if (strobe.clear) begin
        step     <= '0;
        done     <= 1'b0;
        allMatch <= 1'b1;
        failStep <= '0;
      end
      if (strobe.advance) step <= step + 1'b1;
      if (strobe.load) begin
        tck <= 1'b0;
        tms <= entry.tms;
        tdi <= entry.tdi;
      end
      if (strobe.sample) begin
        tck <= 1'b1;
        if (mismatch) begin
          allMatch <= 1'b0;
          if (allMatch) failStep <= step;
        end
      end
      if (strobe.finish) begin
        tck  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign pass = done && allMatch;

endmodule

// File: rtl/bscan_seq.sv
module bscan_seq
  import bscan_seq_pkg::*;
#(
  parameter int BND_LEN = 4,
  parameter int PROG_DEPTH = 64,
  parameter logic [BND_LEN-1:0] PRELOAD = 4'b0100,
  parameter logic [BND_LEN-1:0] EXPECT = 4'b0010,
  parameter logic [BND_LEN-1:0] CARE = 4'b0011,
  localparam int AW = $clog2(PROG_DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          tdo,
  output logic          tck,
  output logic          tms,
  output logic          tdi,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] failStep
);

  localparam int PROG_LEN = progLen(IR_LEN, BND_LEN);

  strobeT strobe;
  logic   lastStep;
  logic   busy;

  bscan_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastStep(lastStep),
    .strobe  (strobe),
    .busy    (busy)
  );

  bscan_seq_dp #(
    .BND_LEN(BND_LEN), .DEPTH(PROG_DEPTH), .AW(AW), .PROG_LEN(PROG_LEN),
    .PRELOAD(PRELOAD), .EXPECT(EXPECT), .CARE(CARE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tdo     (tdo),
    .lastStep(lastStep),
    .tck     (tck),
    .tms     (tms),
    .tdi     (tdi),
    .done    (done),
    .pass    (pass),
    .failStep(failStep)
  );

endmodule

// File: rtl/bscan_seq_chk.sv
module bscan_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          tck,
  input logic          tms,
  input logic          tdi,
  input logic          done,
  input logic          pass,
  input logic [AW-1:0] failStep,
  input logic          busy
);

  AST_PINS_MOVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(tms) || !$stable(tdi)) |-> !tck); // R3

  AST_TCK_ONE_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    tck |=> !tck); // R2

  AST_PASS_ONLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(pass) && $stable(failStep))); // R7

  AST_PASS_NO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (failStep == '0)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tck && start) |=> tck); // R9

  AST_NOT_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R9

  AST_END_TMS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> tms); // R10

endmodule

bind bscan_seq bscan_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .tck     (tck),
  .tms     (tms),
  .tdi     (tdi),
  .done    (done),
  .pass    (pass),
  .failStep(failStep),
  .busy    (busy)
);

// File: tb/sim_bscan_seq.sv
module sim_bscan_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  wire  tdo;
  wire  tck, tms, tdi, done, pass;
  wire  [5:0] failStep;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bscan_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .done(done), .pass(pass), .failStep(failStep)
  );

  // ---------------- behavioural device + board loopback ----------------
  typedef enum logic [3:0] {
    TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
    SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR
  } tapE;

  tapE st = SHDR;
  tapE stAt5 = SHDR;
  logic [2:0] ir = 3'b000, idr = 3'b111;
  logic [3:0] sr = 4'h0, upd = 4'h0;
  logic tdoDev = 1'b0;
  int riseCnt = 0;
  int fault = 0;  // 0 none, 1 in-cell1 stuck 0, 2 in-cell0 stuck 1, 3 tdo stuck 0, 4 tdo stuck 1
  int edgeErr = 0;

  function automatic tapE nxt(tapE s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  wire [1:0] drv = (idr == 3'b000) ? upd[3:2] : 2'b00;  // cells 3,2 are outputs
  wire in0 = (fault == 2) ? 1'b1 : drv[1];              // wire from cell 3
  wire in1 = (fault == 1) ? 1'b0 : drv[0];              // wire from cell 2
  assign tdo = (fault == 3) ? 1'b0 : (fault == 4) ? 1'b1 : tdoDev;

  always @(posedge tck) begin
    riseCnt <= riseCnt + 1;
    case (st)
      TLR:  idr <= 3'b111;
      CIR:  ir <= 3'b001;
      SHIR: ir <= {tdi, ir[2:1]};
      UIR:  idr <= ir;
      CDR: begin
        if (idr == 3'b001)      sr <= {drv, in1, in0};
        else if (idr == 3'b000) sr <= {~upd[3], ~upd[2], in1, in0};
      end
      SHDR: sr <= {tdi, sr[3:1]};
      UDR:  if (idr == 3'b001 || idr == 3'b000) upd <= sr;
      default: ;
    endcase
    st <= nxt(st, tms);
  end

  always @(negedge tck) begin
    tdoDev <= (st == SHIR) ? ir[0] : (st == SHDR) ? sr[0] : 1'b0;
    if (riseCnt == 5) stAt5 <= st;
  end

  // pins may only move while tck is low (R3)
  logic prevTms = 1'b1, prevTdi = 1'b0;
  always @(negedge clk) begin
    if (rstN && tck && (tms !== prevTms || tdi !== prevTdi)) edgeErr++;
    prevTms = tms;
    prevTdi = tdi;
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] mode;
    logic       expPass;
    logic [5:0] expFail;
  } vecT;

  localparam vecT VEC [6] = '{
    '{3'd0, 1'b1, 6'd0},
    '{3'd1, 1'b0, 6'd34},
    '{3'd0, 1'b1, 6'd0},
    '{3'd2, 1'b0, 6'd33},
    '{3'd3, 1'b0, 6'd10},
    '{3'd4, 1'b0, 6'd11}
  };

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state, during reset
    check(tck == 1'b0, "R1", "tck in reset", tck, 0);
    check(tms == 1'b1, "R1", "tms in reset", tms, 1);
    check(tdi == 1'b0, "R1", "tdi in reset", tdi, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(pass == 1'b0, "R1", "pass in reset", pass, 0);
    check(failStep == 6'd0, "R1", "failStep in reset", failStep, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(tck == 1'b0 && tms == 1'b1 && done == 1'b0, "R1", "idle after reset",
          {tck, tms, done}, 3'b010);

    foreach (VEC[k]) begin
      st = SHDR; idr = 3'b111; ir = 3'b000; sr = 4'h0; upd = 4'h0;
      riseCnt = 0; tdoDev = 1'b0; fault = int'(VEC[k].mode);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (!done && cnt < 1000) begin
        @(posedge clk);
        cnt++;
        @(negedge clk);
        start = (cnt == 40);  // R9: request while running
      end
      start = 1'b0;
      check(cnt == 88, "R2", "clocks to done", cnt, 88);
      check(riseCnt == 44, "R9", "tck rises in run", riseCnt, 44);
      check(stAt5 == TLR, "R4", "device state after 5 steps", stAt5, TLR);
      check(pass == VEC[k].expPass, "R6", "pass", pass, VEC[k].expPass);
      check(failStep == VEC[k].expFail, "R8", "failStep", failStep, VEC[k].expFail);
      if (VEC[k].mode >= 3)
        check(failStep == VEC[k].expFail, "R5", "IR capture compare", failStep, VEC[k].expFail);
      check(tms == 1'b1 && st == TLR, "R10", "ends in reset", st, TLR);
      if (k == 2) check(pass == 1'b1, "R11", "restart clears old failure", pass, 1);
      repeat (5) @(negedge clk);
      check(done && pass == VEC[k].expPass && failStep == VEC[k].expFail, "R7",
            "result held", {done, pass}, {1'b1, VEC[k].expPass});
    end

    check(edgeErr == 0, "R3", "pin change while tck high", edgeErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule